// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block sits at the local-bus side of a bus bridge. It maps each local-bus address onto a downstream bus through three programmable windows. Every window has two registers. The start register holds the local start address, a size code, an enable bit and a prefetch flag. The target register holds the upper downstream address bits and a cycle-type field. On a request, the windows are tested from window 0 upward and the first window that covers the address supplies the translation. One clock later the block presents the translated address, the cycle kind (memory, I/O or configuration), a burst hint, a prefetch hint and the index of the winning window. When no window covers the address, it raises a miss flag instead.

Windows may overlap on purpose. Software can enlarge a low-numbered window so that it hides a higher one, reprogram the hidden window (for example into a configuration aperture) and then shrink the low window again. A system register carries a lock bit. While the lock bit is set, the window registers cannot be changed. A single key value clears the lock.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset, `xl_cyc`, `xl_miss`, `xl_addr`, `xl_kind`, `xl_burst`, `xl_prefetch` and `xl_win` are all zero. All window registers read 0, and the system register (select 6) reads 0x4000, which means it is locked.
- R2: While bit 14 of the system register is 1, writes to the window registers (selects 0 to 5) have no effect. Reading them back returns the earlier value.
- R3: While the register is locked, a write of 0x....A05F (low 16 bits) to select 6 stores 0xA05F and clears the lock, and any other write to select 6 is ignored. While it is unlocked, a write to select 6 stores the low 16 bits, so a value with bit 14 set locks the registers again.
- R4: Window w covers an address only when its enable bit (start register bit 0) is 1. The window size is 2^(20+code) bytes, where code is start register bits [7:4]; codes above 9 act as 9 (512 MB). An address hits when its bits above the size match the start register's bits above the size.
- R5: On a hit, the translated address takes its bits above the window size from the target register and its bits below the size from the request address.
- R6: When several windows cover an address, the lowest-numbered window is used, and `xl_win` reports its index.
- R7: Window 2 always yields I/O (`xl_kind`=1) with no burst. Windows 0 and 1 yield configuration (`xl_kind`=2) when target bits [1:0] are 01; otherwise they yield memory (`xl_kind`=0), and `xl_burst`=1 when those bits are 10.
- R8: A request that no enabled window covers gives `xl_miss`=1, `xl_cyc`=0 and a zero address, kind, window index and hints.
- R9: The result of a request appears on the cycle after `req_valid` is sampled. It uses the registers as they were before any write in the same cycle, and a write affects requests from the next cycle on. Without a request, both `xl_cyc` and `xl_miss` are 0.
- R10: Reading a select returns the last value stored there. Window registers return all 32 bits and the system register returns its 16 bits zero-extended. Selects 6 and 7 are not window registers, and select 7 reads 0.
- R11: `xl_prefetch` equals start register bit 1 of the winning window when the result is a memory cycle from window 0 or 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 2w = start of window w, 2w+1 = target of window w, 6 = system |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| xl_cyc | output | 1 | A downstream cycle is issued for last cycle's request |
| xl_miss | output | 1 | Last cycle's request matched no window |
| xl_addr | output | 32 | Translated downstream address |
| xl_kind | output | 2 | 0 memory, 1 I/O, 2 configuration |
| xl_burst | output | 1 | Memory cycle with multiple transfers |
| xl_prefetch | output | 1 | Winning memory window is prefetchable |
| xl_win | output | 2 | Index of the winning window |

## Verification
A register write and a translation request can land in the same cycle. The worst case is a write that disables or resizes the very window the request falls in. The bench issues a request together with a write that turns off window 0, and expects the old mapping to apply. It then repeats the request on the next cycle and expects a miss. The reference model applies writes only after it has computed each cycle's result, so every random and directed cycle in which a write and a request coincide is judged the same way.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_IO  = 2'd1,
    KIND_CFG = 2'd2
  } xw_kind_e;

  localparam int          SYS_W      = 16;
  localparam int          LOCK_BIT   = 14;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [15:0] SYS_RST    = 16'h4000;
  localparam int          EN_BIT     = 0;
  localparam int          PF_BIT     = 1;
  localparam logic [1:0]  MTYPE_CFG   = 2'b01;
  localparam logic [1:0]  MTYPE_MULTI = 2'b10;
endpackage

// File: rtl/xw_rst_sync.sv
module xw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/xw_cfg_regs.sv
module xw_cfg_regs import xw_pkg::*; #(
  parameter int AW    = 32,
  parameter int NWIN  = 3,
  parameter int SEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      wr,
  input  logic [SEL_W-1:0]          sel,
  input  logic [AW-1:0]             wdata,
  output logic [AW-1:0]             rdata,
  output logic [NWIN-1:0][AW-1:0]   start_q,
  output logic [NWIN-1:0][AW-1:0]   tgt_q
);
  localparam logic [SEL_W-1:0] SYS_SEL = SEL_W'(2 * NWIN);

  logic [NWIN-1:0][AW-1:0] start_d, tgt_d;
  logic [SYS_W-1:0]        sys_q, sys_d;
  logic                    locked;

  assign locked = sys_q[LOCK_BIT];

  // next state
  always_comb begin
    start_d = start_q;
    tgt_d   = tgt_q;
    sys_d   = sys_q;
    if (sel == SYS_SEL) begin
      if (!locked)                            sys_d = wdata[SYS_W-1:0];
      else if (wdata[SYS_W-1:0] == UNLOCK_KEY) sys_d = UNLOCK_KEY;
    end else if (!locked) begin
      for (int w = 0; w < NWIN; w++) begin
        if (sel == SEL_W'(2 * w))     start_d[w] = wdata;
        if (sel == SEL_W'(2 * w + 1)) tgt_d[w]   = wdata;
      end
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      tgt_q   <= '0;
      sys_q   <= SYS_RST;
    end else if (wr) begin
      start_q <= start_d;
      tgt_q   <= tgt_d;
      sys_q   <= sys_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel == SEL_W'(2 * w))     rdata = start_q[w];
      if (sel == SEL_W'(2 * w + 1)) rdata = tgt_q[w];
    end
    if (sel == SYS_SEL) rdata = AW'(sys_q);
  end
endmodule

// File: rtl/xw_window.sv
module xw_window import xw_pkg::*; #(
  parameter int AW       = 32,
  parameter int IDX      = 0,
  parameter int NWIN     = 3,
  parameter int MIN_SH   = 20,
  parameter int MAX_CODE = 9,
  parameter int SZ_LSB   = 4,
  parameter int SZ_W     = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] tgt,
  output logic          hit,
  output logic [AW-1:0] xaddr,
  output logic [1:0]    kind,
  output logic          burst,
  output logic          pref
);
  localparam int SH_W = $clog2(AW);

  logic [SZ_W-1:0] code;
  logic [SH_W-1:0] sh;
  logic [AW-1:0]   lo_mask;

  always_comb begin
    code = start[SZ_LSB +: SZ_W];
    if (code > SZ_W'(MAX_CODE)) sh = SH_W'(MIN_SH + MAX_CODE);
    else                        sh = SH_W'(MIN_SH) + SH_W'(code);
    lo_mask = (AW'(1) << sh) - AW'(1);
    hit     = start[EN_BIT] && ((addr & ~lo_mask) == (start & ~lo_mask));
    xaddr   = (tgt & ~lo_mask) | (addr & lo_mask);
  end

  generate
    if (IDX == NWIN - 1) begin : g_io
      assign kind  = KIND_IO;
      assign burst = 1'b0;
      assign pref  = 1'b0;
    end else begin : g_mem
      always_comb begin
        if (tgt[1:0] == MTYPE_CFG) kind = KIND_CFG;
        else                       kind = KIND_MEM;
        burst = (tgt[1:0] == MTYPE_MULTI);
        pref  = start[PF_BIT] && (tgt[1:0] != MTYPE_CFG);
      end
    end
  endgenerate
endmodule

// File: rtl/xw_prio_pick.sv
module xw_prio_pick #(
  parameter int AW    = 32,
  parameter int NWIN  = 3,
  parameter int WIN_W = 2
) (
  input  logic [NWIN-1:0]           hit,
  input  logic [NWIN-1:0][AW-1:0]   xaddr,
  input  logic [NWIN-1:0][1:0]      kind,
  input  logic [NWIN-1:0]           burst,
  input  logic [NWIN-1:0]           pref,
  output logic                      any,
  output logic [WIN_W-1:0]          win,
  output logic [AW-1:0]             addr,
  output logic [1:0]                kind_o,
  output logic                      burst_o,
  output logic                      pref_o
);
  // scan from the top down so the lowest hit is written last
  always_comb begin
    any     = |hit;
    win     = '0;
    addr    = '0;
    kind_o  = '0;
    burst_o = 1'b0;
    pref_o  = 1'b0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        win     = WIN_W'(w);
        addr    = xaddr[w];
        kind_o  = kind[w];
        burst_o = burst[w];
        pref_o  = pref[w];
      end
    end
  end
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat import xw_pkg::*; #(
  parameter int AW       = 32,
  parameter int NWIN     = 3,
  parameter int MIN_SH   = 20,
  parameter int MAX_CODE = 9,
  parameter int SZ_LSB   = 4,
  parameter int SZ_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [$clog2(2*NWIN+1)-1:0]   cfg_sel,
  input  logic [AW-1:0]                 cfg_wdata,
  output logic [AW-1:0]                 cfg_rdata,
  input  logic                          req_valid,
  input  logic [AW-1:0]                 req_addr,
  output logic                          xl_cyc,
  output logic                          xl_miss,
  output logic [AW-1:0]                 xl_addr,
  output logic [1:0]                    xl_kind,
  output logic                          xl_burst,
  output logic                          xl_prefetch,
  output logic [$clog2(NWIN)-1:0]       xl_win
);
  localparam int SEL_W = $clog2(2 * NWIN + 1);
  localparam int WIN_W = $clog2(NWIN);

  logic rst_ni;
  logic [NWIN-1:0][AW-1:0] start_q, tgt_q, w_xaddr;
  logic [NWIN-1:0][1:0]    w_kind;
  logic [NWIN-1:0]         w_hit, w_burst, w_pref;

  logic             p_any, p_burst, p_pref;
  logic [WIN_W-1:0] p_win;
  logic [AW-1:0]    p_addr;
  logic [1:0]       p_kind;

  logic             cyc_d, miss_d, burst_d, pref_d;
  logic [AW-1:0]    addr_d;
  logic [1:0]       kind_d;
  logic [WIN_W-1:0] win_d;

  xw_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  xw_cfg_regs #(.AW(AW), .NWIN(NWIN), .SEL_W(SEL_W)) i_cfg_regs (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr      (cfg_wr),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .start_q (start_q),
    .tgt_q   (tgt_q)
  );

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      xw_window #(
        .AW(AW), .IDX(w), .NWIN(NWIN), .MIN_SH(MIN_SH),
        .MAX_CODE(MAX_CODE), .SZ_LSB(SZ_LSB), .SZ_W(SZ_W)
      ) i_window (
        .addr  (req_addr),
        .start (start_q[w]),
        .tgt   (tgt_q[w]),
        .hit   (w_hit[w]),
        .xaddr (w_xaddr[w]),
        .kind  (w_kind[w]),
        .burst (w_burst[w]),
        .pref  (w_pref[w])
      );
    end
  endgenerate

  xw_prio_pick #(.AW(AW), .NWIN(NWIN), .WIN_W(WIN_W)) i_prio_pick (
    .hit     (w_hit),
    .xaddr   (w_xaddr),
    .kind    (w_kind),
    .burst   (w_burst),
    .pref    (w_pref),
    .any     (p_any),
    .win     (p_win),
    .addr    (p_addr),
    .kind_o  (p_kind),
    .burst_o (p_burst),
    .pref_o  (p_pref)
  );

  // next state of the result stage
  always_comb begin
    cyc_d   = req_valid && p_any;
    miss_d  = req_valid && !p_any;
    addr_d  = cyc_d ? p_addr  : '0;
    kind_d  = cyc_d ? p_kind  : '0;
    win_d   = cyc_d ? p_win   : '0;
    burst_d = cyc_d && p_burst;
    pref_d  = cyc_d && p_pref;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_cyc      <= 1'b0;
      xl_miss     <= 1'b0;
      xl_addr     <= '0;
      xl_kind     <= '0;
      xl_burst    <= 1'b0;
      xl_prefetch <= 1'b0;
      xl_win      <= '0;
    end else begin
      xl_cyc      <= cyc_d;
      xl_miss     <= miss_d;
      xl_addr     <= addr_d;
      xl_kind     <= kind_d;
      xl_burst    <= burst_d;
      xl_prefetch <= pref_d;
      xl_win      <= win_d;
    end
  end
endmodule

// File: rtl/xw_checker.sv
module xw_checker import xw_pkg::*; #(
  parameter int AW    = 32,
  parameter int NWIN  = 3,
  parameter int WIN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [AW-1:0]    req_addr,
  input logic             xl_cyc,
  input logic             xl_miss,
  input logic [AW-1:0]    xl_addr,
  input logic [1:0]       xl_kind,
  input logic             xl_burst,
  input logic             xl_prefetch,
  input logic [WIN_W-1:0] xl_win
);
  // edges seen since reset release; the inner synchronizer needs two
  logic [1:0] up_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_q <= 2'd0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end
  assign live = (up_q >= 2'd2);

  assert_cyc_miss_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_cyc && xl_miss));

  assert_req_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_valid) |=> (xl_cyc ^ xl_miss));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!xl_cyc && !xl_miss));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_addr == '0 && xl_win == '0 && !xl_burst && !xl_prefetch));

  assert_top_is_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_cyc && xl_win == WIN_W'(NWIN - 1)) |-> (xl_kind == KIND_IO));

  assert_burst_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_burst |-> (xl_cyc && xl_kind == KIND_MEM));

  assert_pref_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xl_prefetch |-> (xl_cyc && xl_kind == KIND_MEM));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_valid) |=> (!xl_cyc || xl_addr[19:0] == $past(req_addr[19:0])));
endmodule

bind addr_window_xlat xw_checker #(.AW(AW), .NWIN(NWIN), .WIN_W($clog2(NWIN))) i_xw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .xl_cyc      (xl_cyc),
  .xl_miss     (xl_miss),
  .xl_addr     (xl_addr),
  .xl_kind     (xl_kind),
  .xl_burst    (xl_burst),
  .xl_prefetch (xl_prefetch),
  .xl_win      (xl_win)
);

// File: tb/test_addr_window_xlat.sv
`timescale 1ns/1ps
module test_addr_window_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        xl_cyc, xl_miss, xl_burst, xl_prefetch;
  logic [31:0] xl_addr;
  logic [1:0]  xl_kind, xl_win;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_window_xlat i_addr_window_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .xl_cyc(xl_cyc), .xl_miss(xl_miss), .xl_addr(xl_addr),
    .xl_kind(xl_kind), .xl_burst(xl_burst), .xl_prefetch(xl_prefetch), .xl_win(xl_win)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_start [3];
  logic [31:0] m_tgt [3];
  logic [15:0] m_sys;
  int          m_up;
  logic        e_cyc, e_miss, e_burst, e_pref;
  logic [31:0] e_addr, e_rdata;
  logic [1:0]  e_kind, e_win;

  function automatic logic [31:0] m_read(input logic [2:0] s);
    if (s == 3'd6) return {16'd0, m_sys};
    if (s == 3'd7) return 32'd0;
    if (s[0]) return m_tgt[s[2:1]];
    return m_start[s[2:1]];
  endfunction

  task automatic m_reset();
    for (int w = 0; w < 3; w++) begin m_start[w] = 0; m_tgt[w] = 0; end
    m_sys = 16'h4000;
    e_cyc = 0; e_miss = 0; e_burst = 0; e_pref = 0;
    e_addr = 0; e_kind = 0; e_win = 0;
  endtask

  task automatic m_lookup(input logic [31:0] a);
    bit found = 0;
    e_cyc = 0; e_miss = 0; e_burst = 0; e_pref = 0;
    e_addr = 0; e_kind = 0; e_win = 0;
    for (int w = 0; w < 3; w++) begin
      if (!found && m_start[w][0]) begin
        int code = int'(m_start[w][7:4]);
        longint sz, st;
        if (code > 9) code = 9;
        sz = longint'(1) << (20 + code);
        st = longint'(m_start[w]) - (longint'(m_start[w]) % sz);
        if (longint'(a) >= st && longint'(a) < st + sz) begin
          found = 1;
          e_cyc = 1;
          e_win = 2'(w);
          e_addr = 32'((longint'(m_tgt[w]) - (longint'(m_tgt[w]) % sz)) + (longint'(a) - st));
          if (w == 2) e_kind = 2'd1;
          else begin
            e_kind  = (m_tgt[w][1:0] == 2'b01) ? 2'd2 : 2'd0;
            e_burst = (m_tgt[w][1:0] == 2'b10);
            e_pref  = (e_kind == 2'd0) && m_start[w][1];
          end
        end
      end
    end
    if (!found) e_miss = 1;
  endtask

  task automatic m_write(input logic [2:0] s, input logic [31:0] d);
    bit lk = m_sys[14];
    if (s == 3'd6) begin
      if (!lk) m_sys = d[15:0];
      else if (d[15:0] == 16'hA05F) m_sys = 16'hA05F;
    end else if (s != 3'd7 && !lk) begin
      if (s[0]) m_tgt[s[2:1]] = d;
      else      m_start[s[2:1]] = d;
    end
  endtask

  initial begin m_reset(); m_up = 0; e_rdata = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(); m_up = 0;
    end else if (m_up < 2) begin
      m_up++;
    end else begin
      if (req_valid) m_lookup(req_addr);
      else begin
        e_cyc = 0; e_miss = 0; e_burst = 0; e_pref = 0;
        e_addr = 0; e_kind = 0; e_win = 0;
      end
      if (cfg_wr) m_write(cfg_sel, cfg_wdata);
    end
    e_rdata = m_read(cfg_sel);
  end

  // compare every clock, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!done) begin
        string t;
        t = (!rst_n || m_up < 2) ? "R1" : "R4";
        chk(t, 32'(xl_cyc), 32'(e_cyc));
        chk(rst_n ? "R8" : "R1", 32'(xl_miss), 32'(e_miss));
        chk(rst_n ? "R5" : "R1", xl_addr, e_addr);
        chk(rst_n ? "R7" : "R1", {xl_burst, xl_kind}, {e_burst, e_kind});
        chk(rst_n ? "R6" : "R1", 32'(xl_win), 32'(e_win));
        chk(rst_n ? "R11" : "R1", 32'(xl_prefetch), 32'(e_pref));
        chk(rst_n ? "R10" : "R1", cfg_rdata, e_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = s; cfg_wdata = d; req_valid = 0;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_wr = 0; cfg_sel = s; req_valid = 0;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic req_chk(input logic [31:0] a, input bit ecyc, input logic [31:0] eaddr,
                         input logic [1:0] ekind, input logic [1:0] ewin, input string tag);
    @(negedge clk);
    cfg_wr = 0; req_valid = 1; req_addr = a;
    @(posedge clk);
    #2;
    chk(tag, 32'(xl_cyc), 32'(ecyc));
    chk(tag, 32'(xl_miss), 32'(!ecyc));
    chk(tag, xl_addr, eaddr);
    chk(tag, 32'(xl_kind), 32'(ekind));
    chk(tag, 32'(xl_win), 32'(ewin));
    @(negedge clk);
    req_valid = 0;
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", {30'd0, xl_cyc, xl_miss}, 32'd0);
    rd(3'd6, 32'h4000, "R1");
    rd(3'd0, 32'h0, "R1");

    // R2: locked writes ignored
    wr(3'd0, 32'h4000_0081);
    rd(3'd0, 32'h0, "R2");
    // R3: non-key write ignored, key unlocks
    wr(3'd6, 32'h0000_1234);
    rd(3'd6, 32'h4000, "R3");
    wr(3'd6, 32'hFFFF_A05F);
    rd(3'd6, 32'hA05F, "R3");

    wr(3'd0, 32'h4000_0081);   // 256 MB, enabled
    wr(3'd1, 32'h0000_0002);   // memory multiple
    wr(3'd2, 32'h5000_0083);   // 256 MB, prefetch
    wr(3'd3, 32'h1000_0000);   // plain memory
    wr(3'd4, 32'h6000_0041);   // 16 MB
    wr(3'd5, 32'h0000_0000);
    rd(3'd2, 32'h5000_0083, "R10");
    rd(3'd7, 32'h0, "R10");

    req_chk(32'h4123_4567, 1, 32'h0123_4567, 2'd0, 2'd0, "R5");
    req_chk(32'h4FFF_FFFF, 1, 32'h0FFF_FFFF, 2'd0, 2'd0, "R4");
    req_chk(32'h5ABC_DEF0, 1, 32'h1ABC_DEF0, 2'd0, 2'd1, "R11");
    req_chk(32'h60FF_FFFC, 1, 32'h00FF_FFFC, 2'd1, 2'd2, "R7");
    req_chk(32'h6100_0000, 0, 32'h0, 2'd0, 2'd0, "R8");
    req_chk(32'h3FFF_FFFF, 0, 32'h0, 2'd0, 2'd0, "R8");

    // R6: overlap, window 0 grown to 512 MB hides window 1
    wr(3'd0, 32'h4000_0091);
    req_chk(32'h5ABC_DEF0, 1, 32'h1ABC_DEF0, 2'd0, 2'd0, "R6");
    wr(3'd2, 32'h6100_0041);
    wr(3'd3, 32'h0A00_0001);
    req_chk(32'h6100_0010, 1, 32'h0A00_0010, 2'd2, 2'd1, "R7");
    wr(3'd2, 32'h5000_0083);
    wr(3'd3, 32'h1000_0000);
    wr(3'd0, 32'h4000_0081);
    req_chk(32'h5ABC_DEF0, 1, 32'h1ABC_DEF0, 2'd0, 2'd1, "R6");

    // R4: size code above 9 saturates to 512 MB
    wr(3'd0, 32'h4000_00F1);
    req_chk(32'h5000_0000, 1, 32'h1000_0000, 2'd0, 2'd0, "R4");
    wr(3'd0, 32'h4000_0081);

    // R9: write and request in the same cycle
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 3'd0; cfg_wdata = 32'h4000_0080;
    req_valid = 1; req_addr = 32'h4000_0010;
    @(posedge clk); #2;
    chk("R9", {30'd0, xl_cyc, xl_miss}, 32'd2);
    chk("R9", xl_addr, 32'h0000_0010);
    @(negedge clk);
    cfg_wr = 0;
    @(posedge clk); #2;
    chk("R9", {30'd0, xl_cyc, xl_miss}, 32'd1);
    @(negedge clk);
    req_valid = 0;
    wr(3'd0, 32'h4000_0081);

    // R3: relock, then R2 writes ignored
    wr(3'd6, 32'h0000_4000);
    rd(3'd6, 32'h4000, "R3");
    wr(3'd4, 32'h0000_0000);
    rd(3'd4, 32'h6000_0041, "R2");
    req_chk(32'h6000_0004, 1, 32'h0000_0004, 2'd1, 2'd2, "R2");
    wr(3'd6, 32'h0000_A05F);

    // random traffic against the model, writes mixed in
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      req_addr = 32'h3800_0000 + $urandom_range(0, 32'h2A00_0000);
      cfg_wr = ($urandom_range(0, 9) == 0);
      cfg_sel = 3'($urandom_range(0, 7));
      cfg_wdata = {$urandom_range(32'h38, 32'h62), 20'd0} | 32'($urandom_range(0, 255));
      if (cfg_sel == 3'd6) cfg_wdata = 32'h0000_A05F;
    end
    @(negedge clk);
    cfg_wr = 0; req_valid = 0;

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1", {30'd0, xl_cyc, xl_miss}, 32'd0);
    rd(3'd6, 32'h4000, "R1");
    rst_n = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule